// File: doc/BRIEF.md
# Super I/O Configuration Port Decoder

This block decodes a pair of adjacent I/O addresses into the configuration space of a legacy-style peripheral controller. The even address is the index port and the odd address above it is the data port. At power-up the space is locked. Software opens it by writing a two-byte key to the index port. It then picks a register by writing its number to the index port, and reads or writes that register through the data port. Writing the exit byte to the index port locks the space again.

A global selector register chooses one of several logical devices. The per-device registers behind it are an enable bit, two 16-bit I/O bases and an interrupt line number. The block holds one copy of these registers for each implemented device. It drives them out continuously so that the attached peripherals can decode their own windows and route their interrupts.

Top module: `sio_cfg_decoder`

## Requirements
- R1: From the locked state, two consecutive index-port writes of 0x87 unlock the space. Any other index-port write in between restarts the key. Data-port accesses between the two key writes neither count toward the key nor break it.
- R2: While unlocked, an index-port write of 0xAA locks the space and leaves every register unchanged.
- R3: While locked, data-port writes change nothing, and every read returns 0x00 on `io_rdata`.
- R4: While unlocked, any index-port write other than 0xAA becomes the selected register number. A read of the index port returns that number.
- R5: Register 0x07 is the 8-bit logical device selector. It reads back the value written to it and is 0x00 after reset.
- R6: A per-device register access reaches only the device whose number equals the selector. Implemented device numbers map to output slots 0 to 6 in this order: 0x01, 0x02, 0x04, 0x05, 0x06, 0x07, 0x0A.
- R7: Bit 0 of register 0x30 is the device enable and drives `dev_active[slot]`. Bits 7:1 of a read are 0.
- R8: Registers 0x60 and 0x61 are the high and low bytes of the first base, driven on `dev_base0[slot*16 +: 16]`. Registers 0x62 and 0x63 hold the second base in the same way, driven on `dev_base1`.
- R9: Register 0x70 stores the low IRQ_W (default 4) bits of the written byte as the interrupt number, driven on `dev_irq[slot*IRQ_W +: IRQ_W]`. A read returns that number zero-extended.
- R10: Reads of an unimplemented register number, or of per-device registers while the selector names no implemented device, return 0x00. Writes to them change no output.
- R11: After reset the space is locked, the selector and the register number are 0, and every device is disabled with all bases and interrupt numbers at 0.
- R12: Accesses to any address other than the two ports have no effect and read 0x00.
- R13: A write takes effect on the clock edge where `io_wr` is sampled high, and the exported outputs show it from that edge on. Read data is combinational while `io_rd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 0x00 when no read of this block is in progress |
| dev_active | output | NDEV | Enable bit of each device slot |
| dev_base0 | output | NDEV*16 | First I/O base of each slot |
| dev_base1 | output | NDEV*16 | Second I/O base of each slot |
| dev_irq | output | NDEV*IRQ_W | Interrupt number of each slot |

## Verification
Random traffic seldom unlocks the space. It would need two index writes of 0x87 in a row with no other index write between them. Random traffic seldom exits it either. The hardest state to reach is an open space with a valid device selected and a device register indexed. The random stimulus therefore draws index bytes mostly from the key byte, the exit byte and the implemented register numbers. It draws selector values mostly from implemented device numbers, and leaves some room for stray values. Directed sequences cover the remaining cases: a broken key, data accesses between the two key bytes, interrupt-number truncation, an unimplemented selector, and accesses to foreign addresses.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

   localparam int NDEV = 7;

   localparam logic [7:0] KEY_BYTE  = 8'h87;
   localparam logic [7:0] EXIT_BYTE = 8'hAA;

   localparam logic [7:0] IX_LDN  = 8'h07;
   localparam logic [7:0] IX_ACT  = 8'h30;
   localparam logic [7:0] IX_B0H  = 8'h60;
   localparam logic [7:0] IX_B0L  = 8'h61;
   localparam logic [7:0] IX_B1H  = 8'h62;
   localparam logic [7:0] IX_B1L  = 8'h63;
   localparam logic [7:0] IX_IRQ  = 8'h70;

   typedef enum logic [1:0] {
      KS_LOCKED = 2'd0,
      KS_HALF   = 2'd1,
      KS_OPEN   = 2'd2
   } key_state_t;

   // Device number served by each output slot.
   function automatic logic [7:0] slot_ldn(input int slot);
      case (slot)
         0:       return 8'h01;
         1:       return 8'h02;
         2:       return 8'h04;
         3:       return 8'h05;
         4:       return 8'h06;
         5:       return 8'h07;
         6:       return 8'h0A;
         default: return 8'hFF;
      endcase
   endfunction

endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
   import sio_cfg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idx_wr,
   input  logic [7:0] wdata,
   output logic       unlocked,
   output logic       idx_load
);

   key_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (idx_wr) begin
         case (state_q)
            KS_LOCKED: state_d = (wdata == KEY_BYTE) ? KS_HALF : KS_LOCKED;
            KS_HALF:   state_d = (wdata == KEY_BYTE) ? KS_OPEN : KS_LOCKED;
            KS_OPEN:   state_d = (wdata == EXIT_BYTE) ? KS_LOCKED : KS_OPEN;
            default:   state_d = KS_LOCKED;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= KS_LOCKED;
      else        state_q <= state_d;
   end

   assign unlocked = (state_q == KS_OPEN);
   assign idx_load = idx_wr && unlocked && (wdata != EXIT_BYTE);

   AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(idx_wr && wdata == KEY_BYTE)); // R1

   AST_EXIT_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (unlocked && idx_wr && wdata == EXIT_BYTE) |=> !unlocked); // R2

endmodule

// File: rtl/sio_dev_regs.sv
module sio_dev_regs
   import sio_cfg_pkg::*;
#(
   parameter int IRQ_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [7:0]       idx,
   input  logic [7:0]       wdata,
   output logic [7:0]       rdata,
   output logic             active,
   output logic [15:0]      base0,
   output logic [15:0]      base1,
   output logic [IRQ_W-1:0] irq
);

   localparam int PAD_W = 8 - IRQ_W;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         base0  <= '0;
         base1  <= '0;
         irq    <= '0;
      end else if (we) begin
         case (idx)
            IX_ACT: active       <= wdata[0];
            IX_B0H: base0[15:8]  <= wdata;
            IX_B0L: base0[7:0]   <= wdata;
            IX_B1H: base1[15:8]  <= wdata;
            IX_B1L: base1[7:0]   <= wdata;
            IX_IRQ: irq          <= wdata[IRQ_W-1:0];
            default: ;
         endcase
      end
   end

   generate
      if (PAD_W > 0) begin : g_irq_pad
         logic [7:0] irq_rd;
         assign irq_rd = {{PAD_W{1'b0}}, irq};
         always_comb begin
            case (idx)
               IX_ACT:  rdata = {7'b0, active};
               IX_B0H:  rdata = base0[15:8];
               IX_B0L:  rdata = base0[7:0];
               IX_B1H:  rdata = base1[15:8];
               IX_B1L:  rdata = base1[7:0];
               IX_IRQ:  rdata = irq_rd;
               default: rdata = 8'h00;
            endcase
         end
      end else begin : g_irq_full
         always_comb begin
            case (idx)
               IX_ACT:  rdata = {7'b0, active};
               IX_B0H:  rdata = base0[15:8];
               IX_B0L:  rdata = base0[7:0];
               IX_B1H:  rdata = base1[15:8];
               IX_B1L:  rdata = base1[7:0];
               IX_IRQ:  rdata = irq[7:0];
               default: rdata = 8'h00;
            endcase
         end
      end
   endgenerate

   AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable({active, base0, base1, irq})); // R6

endmodule

// File: rtl/sio_cfg_decoder.sv
module sio_cfg_decoder
   import sio_cfg_pkg::*;
#(
   parameter int                ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] CFG_BASE = 16'h002E,
   parameter int                IRQ_W    = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        io_addr,
   input  logic                     io_wr,
   input  logic                     io_rd,
   input  logic [7:0]               io_wdata,
   output logic [7:0]               io_rdata,
   output logic [NDEV-1:0]          dev_active,
   output logic [NDEV*16-1:0]       dev_base0,
   output logic [NDEV*16-1:0]       dev_base1,
   output logic [NDEV*IRQ_W-1:0]    dev_irq
);

   localparam logic [ADDR_W-1:0] IDX_PORT  = CFG_BASE;
   localparam logic [ADDR_W-1:0] DATA_PORT = CFG_BASE + 1'b1;

   generate
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("sio_cfg_decoder: ADDR_W must be at least 2");
      end
      if (CFG_BASE[0] != 1'b0) begin : g_bad_base
         $error("sio_cfg_decoder: CFG_BASE must be even");
      end
      if (IRQ_W < 1 || IRQ_W > 8) begin : g_bad_irq_w
         $error("sio_cfg_decoder: IRQ_W must lie in 1..8");
      end
   endgenerate

   logic       hit_idx, hit_data;
   logic       idx_wr, data_wr;
   logic       unlocked, idx_load;
   logic [7:0] idx_q, ldn_q;
   logic       cfg_wr;

   assign hit_idx  = (io_addr == IDX_PORT);
   assign hit_data = (io_addr == DATA_PORT);
   assign idx_wr   = io_wr && hit_idx;
   assign data_wr  = io_wr && hit_data;
   assign cfg_wr   = data_wr && unlocked;

   sio_key_fsm u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx_wr   (idx_wr),
      .wdata    (io_wdata),
      .unlocked (unlocked),
      .idx_load (idx_load)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= 8'h00;
         ldn_q <= 8'h00;
      end else begin
         if (idx_load) idx_q <= io_wdata;
         if (cfg_wr && idx_q == IX_LDN) ldn_q <= io_wdata;
      end
   end

   logic [NDEV-1:0] ldn_hit;
   logic [NDEV-1:0] bank_we;
   logic [7:0]      bank_rd [NDEV];

   for (genvar g = 0; g < NDEV; g++) begin : g_dev
      assign ldn_hit[g] = (ldn_q == slot_ldn(g));
      assign bank_we[g] = cfg_wr && ldn_hit[g];

      sio_dev_regs #(.IRQ_W(IRQ_W)) u_regs (
         .clk    (clk),
         .rst_n  (rst_n),
         .we     (bank_we[g]),
         .idx    (idx_q),
         .wdata  (io_wdata),
         .rdata  (bank_rd[g]),
         .active (dev_active[g]),
         .base0  (dev_base0[g*16 +: 16]),
         .base1  (dev_base1[g*16 +: 16]),
         .irq    (dev_irq[g*IRQ_W +: IRQ_W])
      );
   end

   logic [7:0] dev_rd;
   always_comb begin
      dev_rd = 8'h00;
      for (int i = 0; i < NDEV; i++) begin
         if (ldn_hit[i]) dev_rd = dev_rd | bank_rd[i];
      end
   end

   always_comb begin
      io_rdata = 8'h00;
      if (io_rd && unlocked) begin
         if (hit_idx)                          io_rdata = idx_q;
         else if (hit_data && idx_q == IX_LDN) io_rdata = ldn_q;
         else if (hit_data)                    io_rdata = dev_rd;
      end
   end

   AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_we)); // R6

   AST_LOCKED_HOLDS_LDN: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |=> $stable(ldn_q)); // R3

   AST_LOCKED_HOLDS_DEVS: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |=> $stable({dev_active, dev_base0, dev_base1, dev_irq})); // R3

   AST_LOCKED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |-> io_rdata == 8'h00); // R3

   AST_FOREIGN_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit_idx && !hit_data) |=> ($stable(idx_q) && $stable(ldn_q) &&
                                  $stable(unlocked))); // R12

endmodule

// File: tb/sio_cfg_decoder_test.sv
module sio_cfg_decoder_test;
   import sio_cfg_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 16;
   localparam logic [15:0] IDXP = 16'h002E;
   localparam logic [15:0] DATP = 16'h002F;
   localparam int IRQ_W = 4;
   localparam int WATCHDOG = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [ADDR_W-1:0] io_addr = '0;
   logic io_wr = 1'b0, io_rd = 1'b0;
   logic [7:0] io_wdata = '0;
   logic [7:0] io_rdata;
   logic [NDEV-1:0] dev_active;
   logic [NDEV*16-1:0] dev_base0, dev_base1;
   logic [NDEV*IRQ_W-1:0] dev_irq;

   int n_tests = 0, n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sio_cfg_decoder #(.ADDR_W(ADDR_W), .CFG_BASE(IDXP), .IRQ_W(IRQ_W)) uut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .dev_active(dev_active),
      .dev_base0(dev_base0), .dev_base1(dev_base1), .dev_irq(dev_irq));

   // Reference model
   int         m_ks;      // 0 locked, 1 half key, 2 open
   logic [7:0] m_idx, m_ldn;
   logic       m_act [NDEV];
   logic [15:0] m_b0 [NDEV], m_b1 [NDEV];
   logic [IRQ_W-1:0] m_irq [NDEV];

   function automatic int slot_of(input logic [7:0] ldn);
      case (ldn)
         8'h01: return 0;  8'h02: return 1;  8'h04: return 2;
         8'h05: return 3;  8'h06: return 4;  8'h07: return 5;
         8'h0A: return 6;
         default: return -1;
      endcase
   endfunction

   task automatic model_reset();
      m_ks = 0; m_idx = 0; m_ldn = 0;
      for (int i = 0; i < NDEV; i++) begin
         m_act[i] = 0; m_b0[i] = 0; m_b1[i] = 0; m_irq[i] = 0;
      end
   endtask

   task automatic model_write(input logic [15:0] a, input logic [7:0] d);
      int s;
      if (a == IDXP) begin
         if (m_ks == 2) begin
            if (d == 8'hAA) m_ks = 0; else m_idx = d;
         end else if (d == 8'h87) m_ks = m_ks + 1;
         else m_ks = 0;
      end else if (a == DATP && m_ks == 2) begin
         if (m_idx == 8'h07) m_ldn = d;
         else begin
            s = slot_of(m_ldn);
            if (s >= 0) begin
               case (m_idx)
                  8'h30: m_act[s] = d[0];
                  8'h60: m_b0[s][15:8] = d;
                  8'h61: m_b0[s][7:0] = d;
                  8'h62: m_b1[s][15:8] = d;
                  8'h63: m_b1[s][7:0] = d;
                  8'h70: m_irq[s] = d[IRQ_W-1:0];
                  default: ;
               endcase
            end
         end
      end
   endtask

   function automatic logic [7:0] model_read(input logic [15:0] a);
      int s;
      if (m_ks != 2) return 8'h00;
      if (a == IDXP) return m_idx;
      if (a != DATP) return 8'h00;
      if (m_idx == 8'h07) return m_ldn;
      s = slot_of(m_ldn);
      if (s < 0) return 8'h00;
      case (m_idx)
         8'h30: return {7'b0, m_act[s]};
         8'h60: return m_b0[s][15:8];
         8'h61: return m_b0[s][7:0];
         8'h62: return m_b1[s][15:8];
         8'h63: return m_b1[s][7:0];
         8'h70: return {{(8-IRQ_W){1'b0}}, m_irq[s]};
         default: return 8'h00;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input logic [127:0] act,
                        input logic [127:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic check_outputs(input string req);
      logic [NDEV-1:0] ea;
      logic [NDEV*16-1:0] e0, e1;
      logic [NDEV*IRQ_W-1:0] ei;
      for (int i = 0; i < NDEV; i++) begin
         ea[i] = m_act[i];
         e0[i*16 +: 16] = m_b0[i];
         e1[i*16 +: 16] = m_b1[i];
         ei[i*IRQ_W +: IRQ_W] = m_irq[i];
      end
      check(dev_active == ea, {req, " dev_active"}, 128'(dev_active), 128'(ea));
      check(dev_base0 == e0, {req, " dev_base0"}, 128'(dev_base0), 128'(e0));
      check(dev_base1 == e1, {req, " dev_base1"}, 128'(dev_base1), 128'(e1));
      check(dev_irq == ei, {req, " dev_irq"}, 128'(dev_irq), 128'(ei));
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d, input bit chk = 0,
                     input string req = "R13");
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(posedge clk);
      model_write(a, d);
      @(negedge clk);
      io_wr = 1'b0;
      if (chk) check_outputs(req);
   endtask

   task automatic rd(input logic [15:0] a, input string req);
      logic [7:0] e;
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #1;
      e = model_read(a);
      check(io_rdata == e, req, 128'(io_rdata), 128'(e));
      @(negedge clk);
      io_rd = 1'b0;
   endtask

   task automatic unlock();
      wr(IDXP, 8'h87); wr(IDXP, 8'h87);
   endtask

   task automatic set_reg(input logic [7:0] ix, input logic [7:0] d);
      wr(IDXP, ix); wr(DATP, d);
   endtask

   function automatic logic [7:0] pick_index();
      case ($urandom % 12)
         0, 1: return 8'h87;
         2:    return 8'hAA;
         3:    return 8'h07;
         4:    return 8'h30;
         5:    return 8'h60;
         6:    return 8'h61;
         7:    return 8'h62;
         8:    return 8'h63;
         9:    return 8'h70;
         default: return 8'($urandom);
      endcase
   endfunction

   function automatic logic [7:0] pick_ldn();
      case ($urandom % 9)
         0: return 8'h01; 1: return 8'h02; 2: return 8'h04; 3: return 8'h05;
         4: return 8'h06; 5: return 8'h07; 6: return 8'h0A; 7: return 8'h03;
         default: return 8'($urandom);
      endcase
   endfunction

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog (R13): actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : stim
      logic [15:0] a;
      logic [7:0] d;
      void'($urandom(32'h5eed1234));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      check_outputs("R11");
      rd(IDXP, "R11 locked index read");
      rd(DATP, "R11 locked data read");

      // R3 locked writes ignored
      wr(DATP, 8'hFF, 1, "R3");
      unlock();
      rd(IDXP, "R11 index zero after reset");
      wr(IDXP, 8'h07); rd(DATP, "R5 selector zero after reset");
      wr(IDXP, 8'hAA);

      // R1 broken key: 87, 12, 87 stays locked
      wr(IDXP, 8'h87); wr(IDXP, 8'h12); wr(IDXP, 8'h87);
      rd(IDXP, "R1 broken key stays locked");
      wr(IDXP, 8'h87);
      rd(IDXP, "R1 second key after restart opens");
      wr(IDXP, 8'hAA);

      // R1 data access between key bytes does not break the key
      wr(IDXP, 8'h87); wr(DATP, 8'h55); rd(DATP, "R1 data read mid-key");
      wr(IDXP, 8'h87);
      wr(IDXP, 8'h30); rd(IDXP, "R1 R4 index read after key with data gap");

      // R5 R6 R7 R8 R9 program slot 6 (0x0A)
      set_reg(8'h07, 8'h0A); rd(DATP, "R5 selector readback");
      set_reg(8'h30, 8'hFF); rd(DATP, "R7 enable read");
      set_reg(8'h60, 8'h03); set_reg(8'h61, 8'hF8);
      set_reg(8'h62, 8'h02); set_reg(8'h63, 8'hE8);
      set_reg(8'h70, 8'hB7); rd(DATP, "R9 irq truncated read");
      check_outputs("R6 R7 R8 R9");
      wr(IDXP, 8'h61); rd(DATP, "R8 base0 low read");

      // R10 unimplemented index and device
      wr(IDXP, 8'h31); rd(DATP, "R10 unimplemented index read");
      wr(DATP, 8'h77, 1, "R10 unimplemented index write");
      set_reg(8'h07, 8'h03);
      wr(IDXP, 8'h30); rd(DATP, "R10 unimplemented device read");
      wr(DATP, 8'h01, 1, "R10 unimplemented device write");

      // R12 foreign addresses
      wr(16'h002D, 8'hAA, 1, "R12"); wr(16'h0030, 8'h07, 1, "R12");
      rd(IDXP, "R12 index unchanged by foreign write");
      rd(16'h0030, "R12 foreign read");

      // R2 exit keeps registers
      wr(IDXP, 8'hAA, 1, "R2");
      rd(IDXP, "R2 locked after exit");
      unlock();
      rd(IDXP, "R2 index kept across lock");

      // Random phase
      for (int n = 0; n < 4000; n++) begin
         case ($urandom % 10)
            0, 1, 2, 3: begin a = IDXP; d = pick_index(); end
            4, 5, 6:    begin
               a = DATP;
               d = (m_idx == 8'h07) ? pick_ldn() : 8'($urandom);
            end
            default:    begin a = 16'($urandom % 64); d = 8'($urandom); end
         endcase
         if ($urandom % 3 == 0) rd(a, "R4 R6 R10 random read");
         else wr(a, d, 1, "R6 R13 random write");
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule